// File: doc/BRIEF.md
# PoE Port Power Sequencer

This block is the control state machine for a single power-sourcing Ethernet port. It runs the port through signature detection, then classification, then the powered state. While powered it watches for loss of the powered device, for start, power-cut and current-limit faults, for supply undervoltage and for a host power-off command. Each way of leaving the powered state is followed by its own restart policy. After a disconnect the port goes straight back to detection. After a fault it waits out a programmable cool-down before it retries. After a host power-off it clears its own enable bits and stays idle until the host enables it again.

The analog front end is represented by simple digital handshakes. The sequencer raises a detect or classify request. The measurement logic answers with a one-cycle done strobe, together with a pass flag or a count of classification events. A small write-only register port holds the detect and class enable bits and accepts the power-off command. A status word reports the current state, the last classification result and the reason the port last lost power.

Top module: `poe_port_seq`

## Requirements
- R1: After reset the status word is zero, and `pwr_on`, `det_en`, `cls_en`, `cooldown_active`, `det_req` and `cls_req` are all low.
- R2: A write to address 0x14 loads `det_en` from data bit 0 and `cls_en` from data bit 1. Writes to other addresses leave both bits unchanged. From idle, with `det_en` set and `uvlo` low, the port enters detection.
- R3: In detection, `det_req` is high. A `det_done` with `det_pass` high moves the port to classification only when `cls_en` is set. A failed detection, or a passed one with `cls_en` clear, keeps the port in detection. Clearing `det_en` during detection or classification returns the port to idle.
- R4: In classification, `cls_req` is high. A `cls_done` carrying 1 to 5 events powers the port and records that count in the class field. A count of 0, 6 or 7 returns the port to detection and records 0.
- R5: `pwr_on` is high exactly while the port is in the powered state. Clearing the enable bits while powered does not remove power.
- R6: `mps_lost` in the powered state removes power with cause 1 (disconnect). The port moves directly to detection if `det_en` is set, and to idle otherwise. `mps_lost` has no effect in any other state.
- R7: A start, power-cut or current-limit fault in the powered state moves the port to cool-down with cause 2, 3 or 4 respectively. When several faults occur together, start takes priority over power-cut, and power-cut over current-limit. Faults are ignored outside the powered state.
- R8: Cool-down lasts `cool_len` cycles, and a value of 0 counts as 1. `cooldown_active` is high exactly during those cycles.
- R9: Enable writes during cool-down are stored but not acted on, and `det_req` stays low. When cool-down ends, the port enters detection if `det_en` is then set, and idle otherwise.
- R10: A write to address 0x1A with data bit 0 set clears both enable bits. From the powered state it removes power with cause 5. From detection or classification the port returns to idle. During cool-down the count runs on, and the port then lands in idle. The port stays idle until the host sets the enable bits again.
- R11: `uvlo` forces the port to idle from detection, classification or the powered state (cause 6 when leaving power). It holds the port in idle while asserted.
- R12: In the powered state the priority is `uvlo`, then host power-off, then faults, then `mps_lost`.
- R13: The status word is {cause[8:6], class[5:3], state[2:0]}. State codes: idle 0, detect 1, classify 2, powered 3, cool-down 4. Cause codes: none 0, disconnect 1, start 2, power-cut 3, current-limit 4, host-off 5, undervoltage 6. The cause changes only when power is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register write address |
| reg_wdata | input | DATA_W | Register write data |
| cool_len | input | COOL_W | Cool-down length in clock cycles |
| det_done | input | 1 | Detection measurement finished (one cycle) |
| det_pass | input | 1 | Valid signature found, qualified by det_done |
| cls_done | input | 1 | Classification finished (one cycle) |
| cls_fingers | input | FING_W | Number of classification events, qualified by cls_done |
| flt_start | input | 1 | Start-up fault |
| flt_pcut | input | 1 | Power-cut threshold exceeded |
| flt_ilim | input | 1 | Current-limit fault |
| mps_lost | input | 1 | Maintain-power signature lost |
| uvlo | input | 1 | Supply below undervoltage threshold |
| det_req | output | 1 | Detection requested |
| cls_req | output | 1 | Classification requested |
| pwr_on | output | 1 | Port power switch enable |
| cooldown_active | output | 1 | Cool-down in progress |
| det_en | output | 1 | Detect-enable bit |
| cls_en | output | 1 | Class-enable bit |
| status | output | FING_W+6 | {cause, class, state} |

## Verification
The bench builds the block with `IN_SYNC_STAGES` set to 0. With no synchronizer, each fault, disconnect or undervoltage pulse acts on the very next edge. This lets the scoreboard pin down which event wins when power-off, undervoltage, faults and disconnect arrive in the same cycle. `COOL_W` is set to 6, so the all-ones cool-down length of 63 can be timed in full, alongside the zero-length case. The expected status transitions are queued before each stimulus, so any extra, missing or out-of-order state change shows up directly.

// File: rtl/poe_seq_pkg.sv
package poe_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_DETECT  = 3'd1,
      ST_CLASS   = 3'd2,
      ST_POWERED = 3'd3,
      ST_COOL    = 3'd4
   } port_state_e;

   typedef enum logic [2:0] {
      CAUSE_NONE    = 3'd0,
      CAUSE_DISC    = 3'd1,
      CAUSE_START   = 3'd2,
      CAUSE_PCUT    = 3'd3,
      CAUSE_ILIM    = 3'd4,
      CAUSE_HOSTOFF = 3'd5,
      CAUSE_UVLO    = 3'd6
   } off_cause_e;

   localparam int STATE_W = $bits(port_state_e);
   localparam int CAUSE_W = $bits(off_cause_e);

endpackage

// File: rtl/poe_in_sync.sv
module poe_in_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("poe_in_sync: STAGES must be 0..4");
   end
   if (W < 1) begin : g_bad_width
      $error("poe_in_sync: W must be at least 1");
   end

   if (STAGES == 0) begin : g_pass
      assign q = d;
   end else begin : g_flop
      logic [W-1:0] pipe [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
         end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
         end
      end
      assign q = pipe[STAGES-1];
   end

endmodule

// File: rtl/poe_en_regs.sv
module poe_en_regs #(
   parameter int              ADDR_W   = 8,
   parameter int              DATA_W   = 8,
   parameter logic [ADDR_W-1:0] EN_ADDR  = 'h14,
   parameter logic [ADDR_W-1:0] OFF_ADDR = 'h1A,
   parameter int              DET_BIT  = 0,
   parameter int              CLS_BIT  = 1,
   parameter int              OFF_BIT  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              det_en,
   output logic              cls_en,
   output logic              host_off
);

   if (DET_BIT >= DATA_W || CLS_BIT >= DATA_W || OFF_BIT >= DATA_W) begin : g_bad_bit
      $error("poe_en_regs: bit index outside data width");
   end
   if (DET_BIT == CLS_BIT) begin : g_bad_alias
      $error("poe_en_regs: detect and class bits must differ");
   end
   if (EN_ADDR == OFF_ADDR) begin : g_bad_addr
      $error("poe_en_regs: enable and power-off addresses must differ");
   end

   logic en_hit;

   assign en_hit   = wr && (addr == EN_ADDR);
   assign host_off = wr && (addr == OFF_ADDR) && wdata[OFF_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         det_en <= 1'b0;
         cls_en <= 1'b0;
      end else if (host_off) begin
         det_en <= 1'b0;
         cls_en <= 1'b0;
      end else if (en_hit) begin
         det_en <= wdata[DET_BIT];
         cls_en <= wdata[CLS_BIT];
      end
   end

   // R10: a power-off command leaves both enables clear on the next cycle
   assert_hostoff_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      host_off |=> (!det_en && !cls_en));

   // R2: enables only move on a write to one of the two addresses
   assert_en_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && (addr == EN_ADDR || addr == OFF_ADDR)) |=> ($stable(det_en) && $stable(cls_en)));

endmodule

// File: rtl/poe_cool_timer.sv
module poe_cool_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] len,
   output logic             active,
   output logic             last
);

   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_w
      $error("poe_cool_timer: CNT_W must be 1..32");
   end

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= (len == '0) ? ONE : len;
      end else if (cnt != '0) begin
         cnt <= cnt - ONE;
      end
   end

   assign active = (cnt != '0);
   assign last   = (cnt == ONE);

   // R8: a load always starts a non-empty interval
   assert_load_starts_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> active);

   // R8: the interval does not end before its final cycle
   assert_no_early_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !last && !load) |=> active);

endmodule

// File: rtl/poe_port_fsm.sv
module poe_port_fsm
   import poe_seq_pkg::*;
#(
   parameter int FING_W      = 3,
   parameter int MAX_FINGERS = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              det_en,
   input  logic              cls_en,
   input  logic              host_off,
   input  logic              uvlo,
   input  logic              mps_lost,
   input  logic              flt_start,
   input  logic              flt_pcut,
   input  logic              flt_ilim,
   input  logic              det_done,
   input  logic              det_pass,
   input  logic              cls_done,
   input  logic [FING_W-1:0] cls_fingers,
   input  logic              cool_last,
   output port_state_e       st,
   output logic [FING_W-1:0] cls_rec,
   output off_cause_e        cause,
   output logic              cool_load
);

   if (MAX_FINGERS < 1 || MAX_FINGERS >= (1 << FING_W)) begin : g_bad_fingers
      $error("poe_port_fsm: MAX_FINGERS must be 1..2**FING_W-1");
   end

   port_state_e       st_nxt;
   logic [FING_W-1:0] cls_nxt;
   off_cause_e        cause_nxt;
   logic              cls_ok;
   logic              any_flt;
   logic              abort;

   assign cls_ok  = (cls_fingers != '0) && (int'(cls_fingers) <= MAX_FINGERS);
   assign any_flt = flt_start || flt_pcut || flt_ilim;
   assign abort   = uvlo || host_off || !det_en;

   always_comb begin
      st_nxt    = st;
      cls_nxt   = cls_rec;
      cause_nxt = cause;
      cool_load = 1'b0;
      unique case (st)
         ST_IDLE: begin
            if (det_en && !uvlo && !host_off) st_nxt = ST_DETECT;
         end
         ST_DETECT: begin
            if (abort) st_nxt = ST_IDLE;
            else if (det_done && det_pass && cls_en) st_nxt = ST_CLASS;
         end
         ST_CLASS: begin
            if (abort) begin
               st_nxt = ST_IDLE;
            end else if (cls_done) begin
               if (cls_ok) begin
                  st_nxt  = ST_POWERED;
                  cls_nxt = cls_fingers;
               end else begin
                  st_nxt  = ST_DETECT;
                  cls_nxt = '0;
               end
            end
         end
         ST_POWERED: begin
            if (uvlo) begin
               st_nxt    = ST_IDLE;
               cause_nxt = CAUSE_UVLO;
            end else if (host_off) begin
               st_nxt    = ST_IDLE;
               cause_nxt = CAUSE_HOSTOFF;
            end else if (any_flt) begin
               st_nxt    = ST_COOL;
               cool_load = 1'b1;
               if (flt_start)     cause_nxt = CAUSE_START;
               else if (flt_pcut) cause_nxt = CAUSE_PCUT;
               else               cause_nxt = CAUSE_ILIM;
            end else if (mps_lost) begin
               st_nxt    = det_en ? ST_DETECT : ST_IDLE;
               cause_nxt = CAUSE_DISC;
            end
         end
         ST_COOL: begin
            if (cool_last) st_nxt = (det_en && !uvlo && !host_off) ? ST_DETECT : ST_IDLE;
         end
         default: st_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cls_rec <= '0;
         cause   <= CAUSE_NONE;
      end else begin
         st      <= st_nxt;
         cls_rec <= cls_nxt;
         cause   <= cause_nxt;
      end
   end

   // R11: undervoltage drops any active state to idle
   assert_uvlo_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (uvlo && (st inside {ST_DETECT, ST_CLASS, ST_POWERED})) |=> (st == ST_IDLE));

   // R7: a fault while powered always leads into cool-down
   assert_fault_cool_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_POWERED && !uvlo && !host_off && any_flt) |=> (st == ST_COOL));

   // R6: a disconnect with detection enabled restarts detection at once
   assert_disc_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_POWERED && !uvlo && !host_off && !any_flt && mps_lost && det_en)
      |=> (st == ST_DETECT && cause == CAUSE_DISC));

   // R9: cool-down is left only on its last cycle
   assert_cool_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_COOL && !cool_last) |=> (st == ST_COOL));

endmodule

// File: rtl/poe_port_seq.sv
module poe_port_seq
   import poe_seq_pkg::*;
#(
   parameter int              ADDR_W         = 8,
   parameter int              DATA_W         = 8,
   parameter logic [ADDR_W-1:0] EN_ADDR        = 'h14,
   parameter logic [ADDR_W-1:0] OFF_ADDR       = 'h1A,
   parameter int              COOL_W         = 16,
   parameter int              IN_SYNC_STAGES = 2,
   parameter int              FING_W         = 3,
   parameter int              MAX_FINGERS    = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [DATA_W-1:0]    reg_wdata,
   input  logic [COOL_W-1:0]    cool_len,
   input  logic                 det_done,
   input  logic                 det_pass,
   input  logic                 cls_done,
   input  logic [FING_W-1:0]    cls_fingers,
   input  logic                 flt_start,
   input  logic                 flt_pcut,
   input  logic                 flt_ilim,
   input  logic                 mps_lost,
   input  logic                 uvlo,
   output logic                 det_req,
   output logic                 cls_req,
   output logic                 pwr_on,
   output logic                 cooldown_active,
   output logic                 det_en,
   output logic                 cls_en,
   output logic [FING_W+5:0]    status
);

   localparam int N_ASYNC = 5;

   if (DATA_W < 2) begin : g_bad_data
      $error("poe_port_seq: DATA_W must hold both enable bits");
   end
   if (CAUSE_W + STATE_W != 6) begin : g_bad_pkg
      $error("poe_port_seq: status packing expects 3-bit state and cause");
   end

   logic [N_ASYNC-1:0] raw_in, sync_in;
   logic               s_uvlo, s_mps, s_start, s_pcut, s_ilim;
   logic               host_off;
   logic               cool_load, cool_last;
   port_state_e        st;
   off_cause_e         cause;
   logic [FING_W-1:0]  cls_rec;

   assign raw_in = {uvlo, mps_lost, flt_start, flt_pcut, flt_ilim};

   poe_in_sync #(.STAGES(IN_SYNC_STAGES), .W(N_ASYNC)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (sync_in)
   );

   assign {s_uvlo, s_mps, s_start, s_pcut, s_ilim} = sync_in;

   poe_en_regs #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .EN_ADDR  (EN_ADDR),
      .OFF_ADDR (OFF_ADDR)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (reg_wr),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .det_en   (det_en),
      .cls_en   (cls_en),
      .host_off (host_off)
   );

   poe_cool_timer #(.CNT_W(COOL_W)) u_cool (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (cool_load),
      .len    (cool_len),
      .active (cooldown_active),
      .last   (cool_last)
   );

   poe_port_fsm #(.FING_W(FING_W), .MAX_FINGERS(MAX_FINGERS)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .det_en      (det_en),
      .cls_en      (cls_en),
      .host_off    (host_off),
      .uvlo        (s_uvlo),
      .mps_lost    (s_mps),
      .flt_start   (s_start),
      .flt_pcut    (s_pcut),
      .flt_ilim    (s_ilim),
      .det_done    (det_done),
      .det_pass    (det_pass),
      .cls_done    (cls_done),
      .cls_fingers (cls_fingers),
      .cool_last   (cool_last),
      .st          (st),
      .cls_rec     (cls_rec),
      .cause       (cause),
      .cool_load   (cool_load)
   );

   assign det_req = (st == ST_DETECT);
   assign cls_req = (st == ST_CLASS);
   assign pwr_on  = (st == ST_POWERED);
   assign status  = {cause, cls_rec, st};

   // R8: the timer and the state machine agree on cool-down
   assert_cool_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cooldown_active == (st == ST_COOL));

   // R4: a powered port always carries an accepted class count
   assert_class_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_on |-> (cls_rec != '0 && int'(cls_rec) <= MAX_FINGERS));

   // R13: the cause field only moves when power is removed
   assert_cause_on_drop_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_on |=> $stable(cause));

endmodule

// File: tb/poe_port_seq_tb_top.sv
module poe_port_seq_tb_top;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int COOL_W = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             reg_wr = 1'b0;
   logic [7:0]       reg_addr = '0;
   logic [7:0]       reg_wdata = '0;
   logic [COOL_W-1:0] cool_len = '0;
   logic             det_done = 1'b0, det_pass = 1'b0;
   logic             cls_done = 1'b0;
   logic [2:0]       cls_fingers = '0;
   logic             flt_start = 1'b0, flt_pcut = 1'b0, flt_ilim = 1'b0;
   logic             mps_lost = 1'b0, uvlo = 1'b0;
   logic             det_req, cls_req, pwr_on, cooldown_active, det_en, cls_en;
   logic [8:0]       status;

   always #2.5 clk = ~clk;

   poe_port_seq #(.COOL_W(COOL_W), .IN_SYNC_STAGES(0)) dut_i (
      .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_addr (reg_addr),
      .reg_wdata (reg_wdata), .cool_len (cool_len), .det_done (det_done),
      .det_pass (det_pass), .cls_done (cls_done), .cls_fingers (cls_fingers),
      .flt_start (flt_start), .flt_pcut (flt_pcut), .flt_ilim (flt_ilim),
      .mps_lost (mps_lost), .uvlo (uvlo), .det_req (det_req), .cls_req (cls_req),
      .pwr_on (pwr_on), .cooldown_active (cooldown_active), .det_en (det_en),
      .cls_en (cls_en), .status (status)
   );

   int         checks = 0;
   int         fails = 0;
   bit         reported = 1'b0;
   bit         mon_en = 1'b0;
   logic [8:0] prev_status = '0;
   logic [8:0] exp_q [$];

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!reported) begin
         reported = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      end
   endtask

   // expected status word {cause, class, state} (R13)
   task automatic push(int s, int c, int k);
      exp_q.push_back({3'(k), 3'(c), 3'(s)});
   endtask

   always @(negedge clk) begin
      if (mon_en && status !== prev_status) begin
         if (exp_q.size() == 0) begin
            checks++;
            fails++;
            $display("FAIL R13 unexpected status change actual=%0h expected=none", status);
         end else begin
            check("R13 status sequence", 32'(status), 32'(exp_q.pop_front()));
         end
         prev_status = status;
      end
   end

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic reg_write(logic [7:0] a, logic [7:0] d);
      @(posedge clk); #1;
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic detect(bit pass);
      @(posedge clk); #1;
      det_done = 1'b1; det_pass = pass;
      @(posedge clk); #1;
      det_done = 1'b0; det_pass = 1'b0;
   endtask

   task automatic classify(int f);
      @(posedge clk); #1;
      cls_done = 1'b1; cls_fingers = 3'(f);
      @(posedge clk); #1;
      cls_done = 1'b0; cls_fingers = '0;
   endtask

   task automatic strike(bit s, bit p, bit i, bit m);
      @(posedge clk); #1;
      flt_start = s; flt_pcut = p; flt_ilim = i; mps_lost = m;
      @(posedge clk); #1;
      flt_start = 0; flt_pcut = 0; flt_ilim = 0; mps_lost = 0;
   endtask

   task automatic measure(output int n, output int dseen);
      n = 0; dseen = 0;
      @(negedge clk);
      while (cooldown_active && n < 200) begin
         n++;
         if (det_req) dseen++;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
   end

   initial begin
      int n, ds;
      tick(4);
      @(negedge clk);
      // R1 reset state
      check("R1 status", 32'(status), 0);
      check("R1 outputs", {pwr_on, det_en, cls_en, cooldown_active, det_req, cls_req}, 0);
      @(posedge clk); #1 rst_n = 1'b1;
      mon_en = 1'b1;

      // R2 enable write and idle->detect
      push(1, 0, 0);
      reg_write(8'h14, 8'h03); tick(2);
      check("R2 enables set", {det_en, cls_en}, 2'b11);
      check("R3 det_req in detection", 32'(det_req), 1);
      reg_write(8'h15, 8'h00); tick(1);
      check("R2 other address ignored", {det_en, cls_en}, 2'b11);

      // R3 failed detection stays
      detect(1'b0); tick(2);
      check("R3 failed detect stays", 32'(status[2:0]), 1);
      push(2, 0, 0);
      detect(1'b1); tick(1);
      check("R4 cls_req in classification", 32'(cls_req), 1);

      // R4 invalid counts
      push(1, 0, 0); classify(0); tick(1);
      push(2, 0, 0); detect(1'b1);
      push(1, 0, 0); classify(6); tick(1);
      check("R4 rejected count records 0", 32'(status[5:3]), 0);
      push(2, 0, 0); detect(1'b1);
      push(3, 4, 0); classify(4); tick(1);
      check("R5 pwr_on when powered", 32'(pwr_on), 1);
      check("R4 class field", 32'(status[5:3]), 4);

      // R6 disconnect restarts detection
      push(1, 4, 1); strike(0, 0, 0, 1); tick(1);
      check("R6 power removed on disconnect", 32'(pwr_on), 0);
      strike(0, 0, 0, 1); tick(1);
      check("R6 mps_lost ignored in detection", 32'(status[2:0]), 1);
      strike(0, 0, 1, 0); tick(1);
      check("R7 fault ignored in detection", {status[2:0], cooldown_active}, 4'b0010);

      // R7 power-cut beats current-limit; R9 enable held during cool-down
      cool_len = 6'd5;
      push(2, 4, 1); detect(1'b1);
      push(3, 1, 1); classify(1); tick(1);
      push(4, 1, 3); push(1, 1, 3);
      strike(0, 1, 1, 0);
      fork
         measure(n, ds);
         reg_write(8'h14, 8'h01);
      join
      check("R8 cool-down length 5", 32'(n), 5);
      check("R9 no detection during cool-down", 32'(ds), 0);
      tick(1);
      check("R9 enables after held write", {det_en, cls_en}, 2'b10);
      check("R9 detection after cool-down", 32'(status[2:0]), 1);
      detect(1'b1); tick(2);
      check("R3 pass without cls_en stays", 32'(status[2:0]), 1);
      reg_write(8'h14, 8'h03); tick(1);

      // R7 start priority, R8 zero length
      push(2, 1, 3); detect(1'b1);
      push(3, 2, 3); classify(2); tick(1);
      cool_len = '0;
      push(4, 2, 2); push(1, 2, 2);
      strike(1, 1, 1, 0);
      measure(n, ds);
      check("R8 zero length counts as one", 32'(n), 1);

      // R12 fault beats disconnect; R8 max length; R10 power-off in cool-down
      push(2, 2, 2); detect(1'b1);
      push(3, 3, 2); classify(3); tick(1);
      cool_len = 6'd63;
      push(4, 3, 4); push(0, 3, 4);
      strike(0, 0, 1, 1);
      fork
         measure(n, ds);
         begin tick(3); reg_write(8'h1A, 8'h01); end
      join
      check("R8 cool-down length 63", 32'(n), 63);
      check("R10 enables cleared", {det_en, cls_en}, 2'b00);
      tick(5);
      check("R10 stays idle", {status[2:0], det_req}, 4'b0000);

      // R12 host power-off beats power-cut
      push(1, 3, 4); reg_write(8'h14, 8'h03); tick(2);
      push(2, 3, 4); detect(1'b1);
      push(3, 5, 4); classify(5); tick(1);
      push(0, 5, 5);
      fork
         reg_write(8'h1A, 8'h01);
         begin @(posedge clk); #1 flt_pcut = 1'b1; @(posedge clk); #1 flt_pcut = 1'b0; end
      join
      tick(1);
      check("R10 host off removes power", {pwr_on, det_en, cls_en}, 3'b000);

      // R11 undervoltage
      push(1, 5, 5); reg_write(8'h14, 8'h03); tick(2);
      push(0, 5, 5);
      uvlo = 1'b1; tick(4);
      check("R11 held idle under uvlo", {status[2:0], det_req}, 4'b0000);
      push(1, 5, 5);
      uvlo = 1'b0; tick(2);
      push(2, 5, 5); detect(1'b1);
      push(3, 3, 5); classify(3); tick(1);
      push(0, 3, 6);
      fork
         reg_write(8'h1A, 8'h01);
         begin @(posedge clk); #1 uvlo = 1'b1; end
      join
      tick(2);
      check("R11 uvlo removes power", 32'(pwr_on), 0);
      uvlo = 1'b0; tick(4);
      check("R10 idle after power-off", {status[2:0], det_en, cls_en}, 5'b00000);

      // R5 enables cleared while powered; R6 disconnect with detection off
      push(1, 3, 6); reg_write(8'h14, 8'h03); tick(2);
      push(2, 3, 6); detect(1'b1);
      push(3, 2, 6); classify(2); tick(1);
      reg_write(8'h14, 8'h00); tick(1);
      check("R5 power kept after enable clear", 32'(pwr_on), 1);
      push(0, 2, 1); strike(0, 0, 0, 1); tick(2);
      check("R6 disconnect to idle", 32'(status[2:0]), 0);

      tick(3);
      check("R13 all expected transitions seen", 32'(exp_q.size()), 0);
      summary();
      $finish;
   end

endmodule